// File: doc/BRIEF.md
# Message and Wire Error Interrupt Funnel

This block merges sixty-four error sources into a single upstream interrupt line. The lowest twenty-one sources are physical wires, and a rising edge on any of them latches a pending bit. The remaining forty-three sources have no wire. A peripheral raises one of them by posting a 32-bit write whose data is the source number to a doorbell register. Wired and message sources then share one pending-cause vector and one mask vector. The interrupt line is high while any pending source is unmasked.

Software reaches the block through a small 32-bit register port with a valid/ready handshake. The port exposes two cause words, two mask words and the doorbell. To acknowledge a source, software writes its bit index (not a bitmask) into the cause word of its group. A combinational helper reports the lowest-numbered pending, unmasked source, so a service loop can work upward from index 0 until nothing remains.

Top module: `err_irq_funnel`

## Requirements
- R1: After reset every cause bit is 0, every mask bit is 1, `irqOut` is 0 and `lowValid` is 0.
- R2: A 0-to-1 transition on `wireIrq[i]` (i in 0..20) sets cause bit i at that clock edge. A wire held high does not set the bit again after it has been cleared.
- R3: A write to offset 0x30 with data n in 21..63 sets cause bit n. Any other data value (0..20, or 64 and above) changes nothing.
- R4: A write of value n to offset 0x00 clears cause bit (n mod 32). A write of value n to offset 0x04 clears cause bit 32 + (n mod 32). No other bit changes.
- R5: When a set and a clear hit the same cause bit in the same cycle, the bit ends up set.
- R6: The mask words sit at offset 0x20 (sources 0..31, source i at bit i) and offset 0x24 (sources 32..63, source i at bit i-32). A write replaces the word and a read returns it. A mask bit of 1 hides its source from `irqOut` and from the lowest-index helper. Writing all ones to both words silences the block.
- R7: `irqOut` is 1 exactly one cycle after the cause and mask state held at least one pending, unmasked bit, and 0 otherwise.
- R8: `lowValid` is 1 when any pending bit is unmasked. `lowIdx` is then the smallest such index. Both follow the current state with no delay.
- R9: A read returns its word on `regRdata` with `regRvalid` high in the cycle after the request. The cause words sit at offsets 0x00 and 0x04 (source i at bit i%32 of word i/32). Reads of any other offset, including the doorbell, return 0, and writes to other offsets have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wireIrq | input | 21 | Wired error sources 0..20 |
| regValid | input | 1 | Register access request |
| regReady | output | 1 | Always 1; every request is taken in one cycle |
| regWrite | input | 1 | 1 = write, 0 = read |
| regAddr | input | 8 | Byte offset of the register |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, valid with regRvalid |
| regRvalid | output | 1 | Read data strobe, one cycle after a read request |
| irqOut | output | 1 | Combined upstream interrupt |
| lowIdx | output | 6 | Lowest pending unmasked source index |
| lowValid | output | 1 | lowIdx is meaningful |

## Verification
The bench sets pending bits in three ways: wire edges, in-range doorbell numbers, and out-of-range doorbell numbers (both below 21 and above 63). Comparing the three separates a true set from an ignored one. Clears use index values both below and above 32, which shows that the write is decoded as a bit index modulo the word size and not as a mask. A wire rise placed in the same cycle as a clear of the same bit confirms that the set wins. A long pseudo-random mix of edges, doorbells, clears, mask writes and reads is compared against a behavioural model on every clock. That run exercises the lowest-index helper and the one-cycle interrupt delay under overlapping sources.

// File: rtl/err_irq_funnel_pkg.sv
package err_irq_funnel_pkg;
  localparam int WORD_BITS = 32;
  localparam int WSEL_W = 3;

  typedef enum logic [1:0] {
    RD_ZERO  = 2'd0,
    RD_CAUSE = 2'd1,
    RD_MASK  = 2'd2
  } rdSel_e;

  // strobes from register decode to datapath
  typedef struct packed {
    logic              clrEn;
    logic              maskEn;
    logic              bellEn;
    logic              rdEn;
    rdSel_e            rdSel;
    logic [WSEL_W-1:0] word;
  } strobe_t;
endpackage

// File: rtl/err_irq_ctrl.sv
module err_irq_ctrl
  import err_irq_funnel_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int NUM_WORDS  = 2,
  parameter int CAUSE_BASE = 'h00,
  parameter int MASK_BASE  = 'h20,
  parameter int BELL_ADDR  = 'h30
) (
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  output strobe_t           strobe
);
  localparam int SPAN = 4 * NUM_WORDS;

  logic [ADDR_W-1:0] offC, offM;
  logic aligned, hitC, hitM, hitB;

  always_comb begin
    offC    = regAddr - ADDR_W'(CAUSE_BASE);
    offM    = regAddr - ADDR_W'(MASK_BASE);
    aligned = (regAddr[1:0] == 2'b00);
    hitC    = aligned && (regAddr >= ADDR_W'(CAUSE_BASE)) && (offC < ADDR_W'(SPAN));
    hitM    = aligned && (regAddr >= ADDR_W'(MASK_BASE)) && (offM < ADDR_W'(SPAN));
    hitB    = (regAddr == ADDR_W'(BELL_ADDR));
  end

  always_comb begin
    strobe = '0;
    if (regValid) begin
      if (regWrite) begin
        strobe.clrEn  = hitC;
        strobe.maskEn = hitM;
        strobe.bellEn = hitB;
      end else begin
        strobe.rdEn  = 1'b1;
        strobe.rdSel = hitC ? RD_CAUSE : (hitM ? RD_MASK : RD_ZERO);
      end
      strobe.word = hitC ? WSEL_W'(offC >> 2) : WSEL_W'(offM >> 2);
    end
  end
endmodule

// File: rtl/err_irq_dp.sv
module err_irq_dp
  import err_irq_funnel_pkg::*;
#(
  parameter int NUM_SRC   = 64,
  parameter int NUM_WIRED = 21,
  parameter int NUM_WORDS = NUM_SRC / WORD_BITS,
  parameter int IDX_W     = $clog2(NUM_SRC)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_WIRED-1:0] wireIrq,
  input  strobe_t              strobe,
  input  logic [WORD_BITS-1:0] wdata,
  output logic [NUM_SRC-1:0]   causeVec,
  output logic [NUM_SRC-1:0]   maskVec,
  output logic                 irqOut,
  output logic [WORD_BITS-1:0] rdata,
  output logic                 rvalid
);
  logic [NUM_WORDS-1:0][WORD_BITS-1:0] causeQ, maskQ;
  logic [NUM_WIRED-1:0] wirePrevQ;
  logic [NUM_SRC-1:0]   setVec, clrVec, causeNext;
  logic                 bellHit;
  logic [IDX_W-1:0]     bellIdx;
  logic [WSEL_W+4:0]    clrPos;
  logic [WORD_BITS-1:0] rdNext;
  logic                 irqQ;

  assign causeVec = causeQ;
  assign maskVec  = maskQ;

  // doorbell only reaches the message-signaled range
  assign bellHit = strobe.bellEn && (wdata >= WORD_BITS'(NUM_WIRED))
                                 && (wdata <  WORD_BITS'(NUM_SRC));
  assign bellIdx = wdata[IDX_W-1:0];

  for (genvar g = 0; g < NUM_SRC; g++) begin : gSet
    if (g < NUM_WIRED) begin : gWire
      assign setVec[g] = wireIrq[g] & ~wirePrevQ[g];
    end else begin : gMsg
      assign setVec[g] = bellHit && (bellIdx == IDX_W'(g));
    end
  end

  // clear is coded as word number plus bit index
  assign clrPos = {strobe.word, wdata[4:0]};
  always_comb begin
    clrVec = '0;
    if (strobe.clrEn) clrVec = NUM_SRC'(1) << clrPos;
  end

  // set wins over clear of the same bit
  assign causeNext = (causeVec & ~clrVec) | setVec;

  always_comb begin
    rdNext = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (strobe.word == WSEL_W'(w)) begin
        case (strobe.rdSel)
          RD_CAUSE: rdNext = causeQ[w];
          RD_MASK:  rdNext = maskQ[w];
          default:  rdNext = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      causeQ    <= '0;
      maskQ     <= '1;
      wirePrevQ <= '0;
      irqQ      <= 1'b0;
      rdata     <= '0;
      rvalid    <= 1'b0;
    end else begin
      causeQ    <= causeNext;
      wirePrevQ <= wireIrq;
      irqQ      <= |(causeVec & ~maskVec);
      rvalid    <= strobe.rdEn;
      if (strobe.rdEn) rdata <= rdNext;
      for (int w = 0; w < NUM_WORDS; w++) begin
        if (strobe.maskEn && strobe.word == WSEL_W'(w)) maskQ[w] <= wdata;
      end
    end
  end

  assign irqOut = irqQ;
endmodule

// File: rtl/err_irq_pick.sv
module err_irq_pick #(
  parameter int NUM_SRC = 64,
  parameter int IDX_W   = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] pending,
  output logic [IDX_W-1:0]   lowIdx,
  output logic               lowValid
);
  always_comb begin
    lowIdx   = '0;
    lowValid = 1'b0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pending[i]) begin
        lowIdx   = IDX_W'(i);
        lowValid = 1'b1;
      end
    end
  end
endmodule

// File: rtl/err_irq_funnel.sv
module err_irq_funnel
  import err_irq_funnel_pkg::*;
#(
  parameter int NUM_SRC    = 64,
  parameter int NUM_WIRED  = 21,
  parameter int ADDR_W     = 8,
  parameter int CAUSE_BASE = 'h00,
  parameter int MASK_BASE  = 'h20,
  parameter int BELL_ADDR  = 'h30
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_WIRED-1:0] wireIrq,
  input  logic                 regValid,
  output logic                 regReady,
  input  logic                 regWrite,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [31:0]          regWdata,
  output logic [31:0]          regRdata,
  output logic                 regRvalid,
  output logic                 irqOut,
  output logic [$clog2(NUM_SRC)-1:0] lowIdx,
  output logic                 lowValid
);
  localparam int NUM_WORDS = NUM_SRC / WORD_BITS;
  localparam int IDX_W     = $clog2(NUM_SRC);

  strobe_t            strobe;
  logic [NUM_SRC-1:0] causeVec, maskVec;

  assign regReady = 1'b1;

  err_irq_ctrl #(
    .ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS), .CAUSE_BASE(CAUSE_BASE),
    .MASK_BASE(MASK_BASE), .BELL_ADDR(BELL_ADDR)
  ) uCtrl (
    .regValid(regValid), .regWrite(regWrite), .regAddr(regAddr), .strobe(strobe)
  );

  err_irq_dp #(
    .NUM_SRC(NUM_SRC), .NUM_WIRED(NUM_WIRED), .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .wireIrq(wireIrq), .strobe(strobe), .wdata(regWdata),
    .causeVec(causeVec), .maskVec(maskVec), .irqOut(irqOut),
    .rdata(regRdata), .rvalid(regRvalid)
  );

  err_irq_pick #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) uPick (
    .pending(causeVec & ~maskVec), .lowIdx(lowIdx), .lowValid(lowValid)
  );
endmodule

// File: rtl/err_irq_funnel_chk.sv
module err_irq_funnel_chk #(
  parameter int NUM_SRC    = 64,
  parameter int NUM_WIRED  = 21,
  parameter int ADDR_W     = 8,
  parameter int CAUSE_BASE = 'h00,
  parameter int BELL_ADDR  = 'h30
) (
  input logic                       clk,
  input logic                       rstN,
  input logic [NUM_WIRED-1:0]       wireIrq,
  input logic                       regValid,
  input logic                       regWrite,
  input logic [ADDR_W-1:0]          regAddr,
  input logic [31:0]                regWdata,
  input logic [NUM_SRC-1:0]         causeVec,
  input logic [NUM_SRC-1:0]         maskVec,
  input logic                       irqOut,
  input logic [$clog2(NUM_SRC)-1:0] lowIdx,
  input logic                       lowValid
);
  localparam int IDX_W = $clog2(NUM_SRC);

  logic [NUM_SRC-1:0] pend;
  assign pend = causeVec & ~maskVec;

  // remember last cycle's doorbell and upper-word clear at the ports
  logic             bellQ, clrHiQ;
  logic [IDX_W-1:0] bellIdxQ, clrIdxQ;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bellQ <= 1'b0; clrHiQ <= 1'b0; bellIdxQ <= '0; clrIdxQ <= '0;
    end else begin
      bellQ    <= regValid && regWrite && regAddr == ADDR_W'(BELL_ADDR)
                  && regWdata >= 32'(NUM_WIRED) && regWdata < 32'(NUM_SRC);
      bellIdxQ <= regWdata[IDX_W-1:0];
      clrHiQ   <= regValid && regWrite && regAddr == ADDR_W'(CAUSE_BASE + 4);
      clrIdxQ  <= IDX_W'(32) + IDX_W'(regWdata[4:0]);
    end
  end

  for (genvar g = 0; g < NUM_WIRED; g++) begin : gWireChk
    a_r2_wire_edge: assert property (@(posedge clk) disable iff (!rstN)
      (wireIrq[g] && !$past(wireIrq[g])) |=> causeVec[g]);
  end

  a_r3_bell_sets: assert property (@(posedge clk) disable iff (!rstN)
    bellQ |-> causeVec[bellIdxQ]);

  a_r4_clear_upper: assert property (@(posedge clk) disable iff (!rstN)
    clrHiQ |-> !causeVec[clrIdxQ]);

  a_r6_all_masked: assert property (@(posedge clk) disable iff (!rstN)
    (&maskVec) |=> !irqOut);

  a_r7_irq_rise: assert property (@(posedge clk) disable iff (!rstN)
    (|pend) |=> irqOut);

  a_r7_irq_fall: assert property (@(posedge clk) disable iff (!rstN)
    !(|pend) |=> !irqOut);

  a_r8_low_pending: assert property (@(posedge clk) disable iff (!rstN)
    lowValid |-> (causeVec[lowIdx] && !maskVec[lowIdx]));

  a_r8_low_lowest: assert property (@(posedge clk) disable iff (!rstN)
    lowValid |-> ((pend & ((NUM_SRC'(1) << lowIdx) - NUM_SRC'(1))) == '0));

  a_r8_valid_any: assert property (@(posedge clk) disable iff (!rstN)
    !lowValid |-> (pend == '0));
endmodule

bind err_irq_funnel err_irq_funnel_chk #(
  .NUM_SRC(NUM_SRC), .NUM_WIRED(NUM_WIRED), .ADDR_W(ADDR_W),
  .CAUSE_BASE(CAUSE_BASE), .BELL_ADDR(BELL_ADDR)
) uChk (
  .clk(clk), .rstN(rstN), .wireIrq(wireIrq), .regValid(regValid),
  .regWrite(regWrite), .regAddr(regAddr), .regWdata(regWdata),
  .causeVec(causeVec), .maskVec(maskVec), .irqOut(irqOut),
  .lowIdx(lowIdx), .lowValid(lowValid)
);

// File: tb/tb_err_irq_funnel.sv
module tb_err_irq_funnel;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [20:0] wireIrq = '0;
  logic        regValid = 1'b0, regWrite = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic        regReady, regRvalid, irqOut, lowValid;
  logic [31:0] regRdata;
  logic [5:0]  lowIdx;

  always #2 clk = ~clk;

  err_irq_funnel dut (
    .clk(clk), .rstN(rstN), .wireIrq(wireIrq), .regValid(regValid),
    .regReady(regReady), .regWrite(regWrite), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .regRvalid(regRvalid),
    .irqOut(irqOut), .lowIdx(lowIdx), .lowValid(lowValid)
  );

  int checks = 0, errors = 0;
  logic [20:0] wires = '0;
  // behavioural reference state
  logic [63:0] mCause, mMask;
  logic [20:0] mPrev;
  logic        mIrq, mRv;
  logic [31:0] mRd;
  logic [31:0] rnd = 32'h1234_5678;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int lowestOf(input logic [63:0] p);
    for (int i = 0; i < 64; i++) if (p[i]) return i;
    return -1;
  endfunction

  function automatic logic [31:0] readModel(input logic [7:0] a);
    case (a)
      8'h00:   return mCause[31:0];
      8'h04:   return mCause[63:32];
      8'h20:   return mMask[31:0];
      8'h24:   return mMask[63:32];
      default: return 32'h0;
    endcase
  endfunction

  // one clock: drive at negedge, update model at posedge, compare at next negedge
  task automatic cycle(input bit wr, input bit rd, input logic [7:0] a, input logic [31:0] d);
    logic [63:0] nC, nM;
    logic nIrq, nRv;
    logic [31:0] nRd;
    regValid = wr | rd; regWrite = wr; regAddr = a; regWdata = d; wireIrq = wires;
    nC = mCause; nM = mMask;
    if (wr && a == 8'h00) nC[d[4:0]] = 1'b0;
    if (wr && a == 8'h04) nC[32 + d[4:0]] = 1'b0;
    if (wr && a == 8'h20) nM[31:0] = d;
    if (wr && a == 8'h24) nM[63:32] = d;
    if (wr && a == 8'h30 && d >= 21 && d < 64) nC[d[5:0]] = 1'b1;
    for (int i = 0; i < 21; i++) if (wires[i] && !mPrev[i]) nC[i] = 1'b1;
    nIrq = |(mCause & ~mMask);
    nRv = rd;
    nRd = rd ? readModel(a) : mRd;
    @(posedge clk);
    mCause = nC; mMask = nM; mPrev = wires; mIrq = nIrq; mRv = nRv; mRd = nRd;
    @(negedge clk);
    chk(irqOut == mIrq, "R7 irqOut", 64'(irqOut), 64'(mIrq));
    chk(lowValid == (lowestOf(mCause & ~mMask) >= 0), "R8 lowValid", 64'(lowValid), 64'(lowestOf(mCause & ~mMask) >= 0));
    if (lowestOf(mCause & ~mMask) >= 0)
      chk(int'(lowIdx) == lowestOf(mCause & ~mMask), "R8 lowIdx", 64'(lowIdx), 64'(lowestOf(mCause & ~mMask)));
    chk(regRvalid == mRv, "R9 rvalid", 64'(regRvalid), 64'(mRv));
    if (mRv) chk(regRdata == mRd, "R9 rdata", 64'(regRdata), 64'(mRd));
  endtask

  task automatic expectRead(input logic [7:0] a, input logic [31:0] exp, input string tag);
    cycle(0, 1, a, 0);
    chk(regRdata == exp && regRvalid, tag, 64'(regRdata), 64'(exp));
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    mCause = '0; mMask = '1; mPrev = '0; mIrq = 0; mRv = 0; mRd = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chk(irqOut == 0, "R1 irqOut", 64'(irqOut), 0);
    chk(lowValid == 0, "R1 lowValid", 64'(lowValid), 0);
    chk(regReady == 1, "R9 ready", 64'(regReady), 1);
    expectRead(8'h00, 32'h0, "R1 cause0");
    expectRead(8'h04, 32'h0, "R1 cause1");
    expectRead(8'h20, 32'hFFFF_FFFF, "R1 mask0");
    expectRead(8'h24, 32'hFFFF_FFFF, "R1 mask1");

    // R6 unmask everything and read back
    cycle(1, 0, 8'h20, 32'h0);
    cycle(1, 0, 8'h24, 32'h0);
    expectRead(8'h24, 32'h0, "R6 mask1 readback");

    // R2 wire 3 rising edge
    wires[3] = 1'b1;
    cycle(0, 0, 8'h00, 0);
    expectRead(8'h00, 32'h0000_0008, "R2 wire edge");
    chk(irqOut == 1, "R7 irq after wire", 64'(irqOut), 1);
    chk(lowIdx == 6'd3 && lowValid, "R8 lowIdx wire", 64'(lowIdx), 3);

    // R4 clear by index while wire stays high (R2 no re-set)
    cycle(1, 0, 8'h00, 32'd3);
    cycle(0, 0, 8'h00, 0);
    expectRead(8'h00, 32'h0, "R2 R4 held wire cleared");

    // R3 doorbells in and out of range
    cycle(1, 0, 8'h30, 32'd40);
    expectRead(8'h04, 32'h0000_0100, "R3 bell 40");
    cycle(1, 0, 8'h30, 32'd21);
    cycle(1, 0, 8'h30, 32'd5);
    cycle(1, 0, 8'h30, 32'd64);
    cycle(1, 0, 8'h30, 32'd100);
    expectRead(8'h00, 32'h0020_0000, "R3 bell 21 set, 5 ignored");
    expectRead(8'h04, 32'h0000_0100, "R3 bell 64 100 ignored");
    chk(lowIdx == 6'd21 && lowValid, "R8 lowest of 21,40", 64'(lowIdx), 21);

    // R6 mask hides source 21
    cycle(1, 0, 8'h20, 32'h0020_0000);
    chk(lowIdx == 6'd40 && lowValid, "R6 R8 masked 21", 64'(lowIdx), 40);
    expectRead(8'h20, 32'h0020_0000, "R6 mask0 readback");

    // R4 clear of word 1 uses index mod 32
    cycle(1, 0, 8'h04, 32'd40);
    expectRead(8'h04, 32'h0, "R4 clear 40 mod 32");
    expectRead(8'h00, 32'h0020_0000, "R4 other bits kept");

    // R5 set wins over clear in the same cycle
    wires[7] = 1'b1;
    cycle(1, 0, 8'h00, 32'd7);
    expectRead(8'h00, 32'h0020_0080, "R5 set wins");

    // R6 mask all silences
    cycle(1, 0, 8'h20, 32'hFFFF_FFFF);
    cycle(1, 0, 8'h24, 32'hFFFF_FFFF);
    cycle(0, 0, 8'h00, 0);
    chk(irqOut == 0, "R6 all masked irq", 64'(irqOut), 0);
    chk(lowValid == 0, "R6 all masked low", 64'(lowValid), 0);

    // R9 undefined offsets
    cycle(1, 0, 8'h10, 32'hFFFF_FFFF);
    cycle(1, 0, 8'h34, 32'd22);
    cycle(1, 0, 8'h31, 32'd23);
    expectRead(8'h00, 32'h0020_0080, "R9 stray writes ignored");
    expectRead(8'h04, 32'h0, "R9 stray bells ignored");
    expectRead(8'h10, 32'h0, "R9 undefined read");
    expectRead(8'h30, 32'h0, "R9 doorbell read");
    expectRead(8'h24, 32'hFFFF_FFFF, "R9 mask kept");

    // mixed traffic against the model
    for (int n = 0; n < 3000; n++) begin
      rnd = rnd ^ (rnd << 13); rnd = rnd ^ (rnd >> 17); rnd = rnd ^ (rnd << 5);
      if (rnd[31:29] == 3'd0) wires = wires ^ (21'(rnd) & 21'h0A5A5);
      case (rnd[3:0])
        4'd0, 4'd1, 4'd2: cycle(1, 0, 8'h30, {25'd0, rnd[10:4]});
        4'd3, 4'd4:       cycle(1, 0, 8'h00, {27'd0, rnd[8:4]});
        4'd5, 4'd6:       cycle(1, 0, 8'h04, {27'd0, rnd[8:4]});
        4'd7:             cycle(1, 0, rnd[4] ? 8'h24 : 8'h20, rnd[27:12] == 0 ? 32'hFFFF_FFFF : {rnd[27:12], rnd[15:0]} & {rnd[31:16], 16'hF0F0});
        4'd8, 4'd9:       cycle(0, 1, 8'(rnd[6:4]) << 2 | (rnd[7] ? 8'h20 : 8'h00), 0);
        default:          cycle(0, 0, 8'h00, 0);
      endcase
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule